// File: doc/BRIEF.md
# I2C Bus Busy State Tracker

This block watches the clock and data wires of an I2C bus that several masters share. It tells the local controller whether the bus is taken. It keeps a busy flag, a sticky bus-free event flag, and a flag that marks the busy flag as trustworthy once the controller is switched on. Both wires pass through a synchronizer. Each wire's synchronized level is compared with its level one clock earlier, and the block reacts to three conditions: a START, a STOP, and the data wire held low while the clock wire is high (the acknowledge pattern).

A software reset loads the busy flag from the present wire levels through a fixed table, so the busy flag can start out wrong while another master is in the middle of a transfer. After that the flag follows the wire conditions. Tracking goes on whether the controller is enabled or not. The state machine has two states, `BT_FREE` and `BT_BUSY`, and three named transitions:
- `GO_BUSY` moves from free to busy on a START or on the acknowledge level.
- `GO_FREE` moves from busy to free on a STOP.
- `RELOAD` leaves either state on a software reset and goes to the state the table gives.

Top module: `i2c_busy_tracker`

## Requirements
- R1: After the hardware reset `rst_n`, `bus_busy`, `bus_free_evt` and `busy_valid` are all 0.
- R2: A one-cycle `soft_rst` pulse loads `bus_busy` from the synchronized lines. {SCL=1,SDA=0} gives 1. {SCL=1,SDA=1}, {SCL=0,SDA=0} and {SCL=0,SDA=1} give 0. The pulse also clears `bus_free_evt` and `busy_valid`. Both outputs show the new values one clock later.
- R3: A START (SDA falls while SCL stays high) sets `bus_busy` three clocks after the SDA change reaches the pins, with the default two synchronizer stages.
- R4: SDA low while SCL is high sets `bus_busy`, even when no SDA edge is seen, for example when SCL rises while SDA is already low.
- R5: A STOP (SDA rises while SCL stays high) clears `bus_busy` and sets `bus_free_evt` three clocks after the SDA change.
- R6: `bus_free_evt` stays 1 until a `bf_clr` pulse arrives. It reads 0 on the clock after that pulse.
- R7: If a STOP is detected in the same cycle as `bf_clr`, `bus_free_evt` stays 1.
- R8: `bus_busy` and `bus_free_evt` track the bus the same way whether `enable` is 0 or 1.
- R9: `busy_valid` follows `enable` with a lag of one clock, in both directions.
- R10: SDA changes while SCL is low change neither `bus_busy` nor `bus_free_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse; reloads the busy flag from the line levels |
| enable | input | 1 | Controller enable |
| bf_clr | input | 1 | Write-one-to-clear strobe for the bus-free event flag |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| bus_busy | output | 1 | Bus busy flag |
| bus_free_evt | output | 1 | Sticky flag, set by a STOP |
| busy_valid | output | 1 | Busy flag may be trusted (enable seen one clock earlier) |

## Verification
Two events can land in the same clock: a STOP being detected and a `bf_clr` pulse. In that case the set must win. The bench provokes the clash by raising SDA with SCL high and then driving `bf_clr` in exactly the cycle the detector reports the STOP, which is two clocks after the pin change. It then expects `bus_free_evt` to read 1 afterwards. A lone clear issued before the STOP confirms that the clear path works on its own, so the 1 seen afterwards cannot be a dead clear path.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [0:0] {
        BT_FREE = 1'b0,
        BT_BUSY = 1'b1
    } bt_state_t;

    // Busy value loaded by a software reset from the line levels
    function automatic logic bt_reload_busy(input logic scl, input logic sda);
        logic r;
        unique case ({scl, sda})
            2'b10:   r = 1'b1;  // clock high, data low
            2'b11:   r = 1'b0;
            2'b01:   r = 1'b0;
            default: r = 1'b0;  // both low
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_in;
            end
            assign d_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= {STAGES{RST_VAL}};
                else        q <= {q[STAGES-2:0], d_in};
            end
            assign d_out = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_bt_cond.sv
module i2c_bt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic level_det
);
    logic scl_p;
    logic sda_p;
    logic scl_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edges on data only count while the clock was high in both samples
    assign scl_hold  = scl_s & scl_p;
    assign start_det = scl_hold & sda_p & ~sda_s;
    assign stop_det  = scl_hold & ~sda_p & sda_s;
    assign level_det = scl_s & ~sda_s;
endmodule

// File: rtl/i2c_bt_fsm.sv
module i2c_bt_fsm
    import i2c_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic enable,
    input  logic bf_clr,
    input  logic scl_s,
    input  logic sda_s,
    input  logic start_det,
    input  logic stop_det,
    input  logic level_det,
    output logic bus_busy,
    output logic bus_free_evt,
    output logic busy_valid
);
    bt_state_t state_q;
    bt_state_t state_d;
    logic      bf_q;
    logic      valid_q;

    // Next state: RELOAD over GO_FREE over GO_BUSY
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = bt_reload_busy(scl_s, sda_s) ? BT_BUSY : BT_FREE;
        end else begin
            unique case (state_q)
                BT_FREE: if (!stop_det && (start_det || level_det)) state_d = BT_BUSY;
                BT_BUSY: if (stop_det) state_d = BT_FREE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_FREE;
        else        state_q <= state_d;
    end

    // Sticky event flag and enable lag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bf_q    <= 1'b0;
            valid_q <= 1'b0;
        end else if (soft_rst) begin
            bf_q    <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= enable;
            if (stop_det)    bf_q <= 1'b1;
            else if (bf_clr) bf_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        bus_busy     = (state_q == BT_BUSY);
        bus_free_evt = bf_q;
        busy_valid   = valid_q;
    end
endmodule

// File: rtl/i2c_busy_tracker.sv
module i2c_busy_tracker #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic enable,
    input  logic bf_clr,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy,
    output logic bus_free_evt,
    output logic busy_valid
);
    logic scl_s;
    logic sda_s;
    logic start_det;
    logic stop_det;
    logic level_det;

    i2c_bt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .d_out(scl_s)
    );

    i2c_bt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .d_out(sda_s)
    );

    i2c_bt_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det), .level_det(level_det)
    );

    i2c_bt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .bf_clr(bf_clr), .scl_s(scl_s), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det), .level_det(level_det),
        .bus_busy(bus_busy), .bus_free_evt(bus_free_evt), .busy_valid(busy_valid)
    );
endmodule

// File: rtl/i2c_busy_tracker_chk.sv
module i2c_busy_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic enable,
    input logic bf_clr,
    input logic start_det,
    input logic stop_det,
    input logic level_det,
    input logic bus_busy,
    input logic bus_free_evt,
    input logic busy_valid
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && start_det && !stop_det) |=> bus_busy); // R3

    AST_LEVEL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && level_det) |=> bus_busy); // R4

    AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && stop_det) |=> (!bus_busy && bus_free_evt)); // R5

    AST_BF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !bf_clr && bus_free_evt) |=> bus_free_evt); // R6

    AST_BF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && bf_clr && !stop_det) |=> !bus_free_evt); // R6

    AST_STOP_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && bf_clr && stop_det) |=> bus_free_evt); // R7

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (busy_valid == $past(enable))); // R9

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!bus_free_evt && !busy_valid)); // R2

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R5
endmodule

bind i2c_busy_tracker i2c_busy_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .bf_clr(bf_clr), .start_det(start_det), .stop_det(stop_det),
    .level_det(level_det), .bus_busy(bus_busy), .bus_free_evt(bus_free_evt),
    .busy_valid(busy_valid)
);

// File: tb/i2c_busy_tracker_tb_top.sv
module i2c_busy_tracker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic enable = 1'b0;
    logic bf_clr = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic bus_busy;
    logic bus_free_evt;
    logic busy_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_busy_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .bf_clr(bf_clr), .scl_in(scl_in), .sda_in(sda_in),
        .bus_busy(bus_busy), .bus_free_evt(bus_free_evt), .busy_valid(busy_valid)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_soft();
        soft_rst = 1'b1;
        cyc(1);
        soft_rst = 1'b0;
    endtask

    task automatic pulse_clr();
        bf_clr = 1'b1;
        cyc(1);
        bf_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy after reset", bus_busy, 1'b0);
        check("R1 bf after reset", bus_free_evt, 1'b0);
        check("R1 valid after reset", busy_valid, 1'b0);
    endtask

    task automatic t_start_stop();
        sda_in = 1'b0;            // START
        cyc(2);
        check("R3 busy not yet", bus_busy, 1'b0);
        cyc(1);
        check("R3 busy after start", bus_busy, 1'b1);
        scl_in = 1'b0; cyc(4);
        sda_in = 1'b1; cyc(4);
        sda_in = 1'b0; cyc(4);
        sda_in = 1'b1; cyc(4);
        check("R10 busy kept during data", bus_busy, 1'b1);
        check("R10 bf kept during data", bus_free_evt, 1'b0);
        scl_in = 1'b1; cyc(4);
        sda_in = 1'b0; cyc(4); // repeated START
        check("R3 busy after repeated start", bus_busy, 1'b1);
        sda_in = 1'b1;            // STOP
        cyc(2);
        check("R5 busy before stop seen", bus_busy, 1'b1);
        cyc(1);
        check("R5 busy after stop", bus_busy, 1'b0);
        check("R5 bf after stop", bus_free_evt, 1'b1);
        cyc(20);
        check("R6 bf sticky", bus_free_evt, 1'b1);
        pulse_clr();
        check("R6 bf cleared", bus_free_evt, 1'b0);
    endtask

    task automatic t_clash();
        sda_in = 1'b0; cyc(5);
        check("R7 busy before clash", bus_busy, 1'b1);
        check("R7 bf clear before clash", bus_free_evt, 1'b0);
        sda_in = 1'b1;            // STOP, detected between 2nd and 3rd edge
        cyc(2);
        pulse_clr();
        check("R7 stop wins over clear", bus_free_evt, 1'b1);
        check("R7 busy cleared", bus_busy, 1'b0);
        pulse_clr();
        check("R6 clear after clash", bus_free_evt, 1'b0);
    endtask

    task automatic t_idle_data();
        scl_in = 1'b0; cyc(4);
        sda_in = 1'b0; cyc(4);
        sda_in = 1'b1; cyc(4);
        check("R10 free bus data toggles busy", bus_busy, 1'b0);
        check("R10 free bus data toggles bf", bus_free_evt, 1'b0);
        scl_in = 1'b1; cyc(4);
        check("R10 clock rise with data high", bus_busy, 1'b0);
    endtask

    task automatic t_reload();
        // busy wrong after reload: SCL low, SDA low
        sda_in = 1'b0; cyc(4);     // START -> busy
        scl_in = 1'b0; cyc(4);
        pulse_soft();
        check("R2 table 00 busy", bus_busy, 1'b0);
        scl_in = 1'b1; cyc(3);     // level condition only
        check("R4 level sets busy", bus_busy, 1'b1);
        // table SCL=1 SDA=1 while busy, with bf set
        sda_in = 1'b1; cyc(4);     // STOP
        sda_in = 1'b0; cyc(4);     // START
        check("R2 bf set before reload", bus_free_evt, 1'b1);
        sda_in = 1'b1; scl_in = 1'b0; cyc(4);
        scl_in = 1'b1; cyc(4);     // no stop: data rose while clock low
        check("R10 still busy", bus_busy, 1'b1);
        pulse_soft();
        check("R2 table 11 busy", bus_busy, 1'b0);
        check("R2 reload clears bf", bus_free_evt, 1'b0);
        // SCL low, SDA high
        sda_in = 1'b0; cyc(4);
        scl_in = 1'b0; sda_in = 1'b1; cyc(4);
        pulse_soft();
        check("R2 table 01 busy", bus_busy, 1'b0);
        // SCL high, SDA low
        sda_in = 1'b0; cyc(4);
        scl_in = 1'b1; cyc(4);
        pulse_soft();
        check("R2 table 10 busy", bus_busy, 1'b1);
        sda_in = 1'b1; cyc(4);
        check("R5 free after reload", bus_busy, 1'b0);
        pulse_clr();
    endtask

    task automatic t_enable();
        enable = 1'b1;
        #1;
        check("R9 valid not immediate", busy_valid, 1'b0);
        cyc(1);
        check("R9 valid one clock later", busy_valid, 1'b1);
        sda_in = 1'b0; cyc(4);
        check("R8 start tracked when enabled", bus_busy, 1'b1);
        sda_in = 1'b1; cyc(4);
        check("R8 stop tracked when enabled", bus_free_evt, 1'b1);
        pulse_soft();
        check("R2 reload clears valid", busy_valid, 1'b0);
        cyc(1);
        check("R9 valid returns", busy_valid, 1'b1);
        enable = 1'b0;
        cyc(1);
        check("R9 valid drops", busy_valid, 1'b0);
        sda_in = 1'b0; cyc(4);
        check("R8 start tracked when disabled", bus_busy, 1'b1);
        sda_in = 1'b1; cyc(4);
        check("R8 stop tracked when disabled", bus_free_evt, 1'b1);
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_start_stop();
        t_clash();
        t_idle_data();
        t_reload();
        t_enable();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule